// File: doc/BRIEF.md
# Toggle-Bit Status Poller

This block runs on the host side of a parallel flash. It works out whether a program or erase operation is still running, and in which state a given sector is. A request carries a sector address and a flag that tells the poller whether the host has asked the device to suspend. The poller then issues two back-to-back single reads to that address over a simple request/valid read bus. It compares two status bits between the two returned words. Bit 6 toggles on every read while any embedded operation runs anywhere in the device. Bit 2 toggles only on reads of sectors that are selected for erasure. Neither bit alone gives both mode and sector, so the poller combines them into a 2-bit result code and pulses a done strobe.

The host must not raise a request until the final write strobe of its command sequence has completed. With repeat mode enabled, the poller keeps issuing fresh read pairs while the device reports busy. It stops at a parameterised number of decisions and then reports busy.

Top module: `tgl_poll_ctrl`

## Requirements
- R1: After reset, done_o and rd_req_o are low and result_o is 0.
- R2: A start_i pulse seen while idle latches addr_i. Every read of that poll uses the latched address on rd_addr_o. rd_req_o stays high until rd_valid_i returns the word.
- R3: Each decision uses exactly two consecutive returned words. The total number of reads in a poll is twice the number of decisions.
- R4: If bit 6 differs between the two words, the decision is busy (code 1), whatever bit 2 and the suspend flag show.
- R5: If bit 6 is equal and bit 2 differs, the result is suspended with the sector selected (code 2).
- R6: If both bits are equal, the result is complete (code 0) when the suspend flag is low, or suspended with the sector not selected (code 3) when it is high. The flag is sampled only at the accepted start.
- R7: With repeat enabled, a busy decision starts a new read pair, up to MAX_POLLS decisions. After the last one, busy is reported.
- R8: done_o is high for exactly one cycle per poll. result_o changes only in that cycle and holds its value until the next poll ends.
- R9: start_i is ignored while a poll is in progress. The address and flag of the running poll are kept.
- R10: No read is requested while idle or while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Poll request, accepted when idle |
| addr_i | input | ADDR_W | Sector address to poll |
| suspend_i | input | 1 | Host has suspended the erase |
| done_o | output | 1 | One-cycle end-of-poll strobe |
| result_o | output | 2 | 0 complete, 1 busy, 2 suspended/selected, 3 suspended/unselected |
| rd_req_o | output | 1 | Read request to the flash bus |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DATA_W | Read data word |

## Verification
A flash model flips bit 6 for a set number of reads and can flip bit 2 on every read. Each mix of bit 6 behaviour, bit 2 behaviour and suspend flag is applied. Tying bit 6 to always toggle while bit 2 and the flag vary shows that bit 6 dominates. Stopping bit 6 after one or three flips shows that a later read pair can change the decision, and the read count shows how many pairs were used. A steady bit 6 with bit 2 toggling, compared against a steady bit 6 with bit 2 steady, separates the selected-sector result from the flag-driven complete and unselected results. Directed runs check:
- that a second start during a poll is ignored;
- that a suspend flag dropped after the start has no effect;
- that the done strobe lasts one cycle;
- that no read is requested once the poll has ended.

// File: rtl/tgl_poll_pkg.sv
package tgl_poll_pkg;

   localparam int TGL_DEV_BIT = 6;   // device-wide toggle
   localparam int TGL_SEC_BIT = 2;   // sector-specific toggle

   typedef enum logic [1:0] {
      RES_COMPLETE    = 2'd0,
      RES_BUSY        = 2'd1,
      RES_SUSP_SEL    = 2'd2,
      RES_SUSP_UNSEL  = 2'd3
   } poll_res_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ1,
      ST_READ2,
      ST_DECIDE,
      ST_DONE
   } poll_st_e;

endpackage

// File: rtl/tgl_poll_sample.sv
// Keeps the two tapped status bits of the last two returned words.
// Bit 1 of each pair is the device toggle, bit 0 the sector toggle.
module tgl_poll_sample #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [1:0]        prv_o,
   output logic [1:0]        cur_o
);
   import tgl_poll_pkg::*;

   localparam int NTAP = 2;

   logic [NTAP-1:0] tap;
   logic            unused_rest;

   for (genvar i = 0; i < NTAP; i++) begin : g_tap
      localparam int POS = (i == 0) ? TGL_SEC_BIT : TGL_DEV_BIT;
      assign tap[i] = data_i[POS];
   end

   assign unused_rest = ^data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prv_o <= '0;
         cur_o <= '0;
      end else if (cap_i) begin
         prv_o <= cur_o;
         cur_o <= tap;
      end
   end
endmodule

// File: rtl/tgl_poll_classify.sv
module tgl_poll_classify (
   input  logic [1:0]               prv_i,
   input  logic [1:0]               cur_i,
   input  logic                     susp_i,
   output tgl_poll_pkg::poll_res_e  res_o
);
   import tgl_poll_pkg::*;

   logic dev_tgl, sec_tgl;

   always_comb begin
      dev_tgl = prv_i[1] ^ cur_i[1];
      sec_tgl = prv_i[0] ^ cur_i[0];
      if (dev_tgl)      res_o = RES_BUSY;
      else if (sec_tgl) res_o = RES_SUSP_SEL;
      else if (susp_i)  res_o = RES_SUSP_UNSEL;
      else              res_o = RES_COMPLETE;
   end
endmodule

// File: rtl/tgl_poll_budget.sv
// Counts decisions of one poll; last_o marks the final allowed one.
module tgl_poll_budget #(
   parameter int NPOLL = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   localparam int CW = $clog2(NPOLL + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr_i) cnt <= '0;
      else if (inc_i) cnt <= cnt + 1'b1;
   end

   assign last_o = (cnt == CW'(NPOLL - 1));
endmodule

// File: rtl/tgl_poll_ctrl.sv
module tgl_poll_ctrl #(
   parameter int ADDR_W    = 21,
   parameter int DATA_W    = 16,
   parameter bit REPEAT_EN = 1'b1,
   parameter int MAX_POLLS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              suspend_i,
   output logic              done_o,
   output logic [1:0]        result_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [DATA_W-1:0] rd_data_i
);
   import tgl_poll_pkg::*;

   localparam int EFF_POLLS = REPEAT_EN ? MAX_POLLS : 1;

   if (DATA_W <= TGL_DEV_BIT) begin : g_bad_width
      $error("tgl_poll_ctrl: DATA_W must cover the device toggle bit");
   end
   if (MAX_POLLS < 1) begin : g_bad_polls
      $error("tgl_poll_ctrl: MAX_POLLS must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("tgl_poll_ctrl: ADDR_W must be at least 1");
   end

   poll_st_e          st_q;
   logic [ADDR_W-1:0] addr_q;
   logic              susp_q;
   poll_res_e         res_q;
   poll_res_e         res_d;
   logic [1:0]        prv, cur;
   logic              in_read, cap, last, accept, again;

   assign in_read = (st_q == ST_READ1) || (st_q == ST_READ2);
   assign cap     = in_read && rd_valid_i;
   assign accept  = (st_q == ST_IDLE) && start_i;
   assign again   = (st_q == ST_DECIDE) && (res_d == RES_BUSY) && !last;

   tgl_poll_sample #(.DATA_W(DATA_W)) u_sample (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (cap),
      .data_i (rd_data_i),
      .prv_o  (prv),
      .cur_o  (cur)
   );

   tgl_poll_classify u_cls (
      .prv_i  (prv),
      .cur_i  (cur),
      .susp_i (susp_q),
      .res_o  (res_d)
   );

   tgl_poll_budget #(.NPOLL(EFF_POLLS)) u_budget (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (accept),
      .inc_i  (again),
      .last_o (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         susp_q <= 1'b0;
         res_q  <= RES_COMPLETE;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               addr_q <= addr_i;
               susp_q <= suspend_i;
               st_q   <= ST_READ1;
            end
            ST_READ1: if (rd_valid_i) st_q <= ST_READ2;
            ST_READ2: if (rd_valid_i) st_q <= ST_DECIDE;
            ST_DECIDE: begin
               if (again) begin
                  st_q <= ST_READ1;
               end else begin
                  res_q <= res_d;
                  st_q  <= ST_DONE;
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_req_o  = in_read;
   assign rd_addr_o = addr_q;
   assign done_o    = (st_q == ST_DONE);
   assign result_o  = res_q;
endmodule

// File: rtl/tgl_poll_chk.sv
module tgl_poll_chk #(
   parameter int ADDR_W = 21
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              done_o,
   input logic [1:0]        result_o,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              rd_valid_i
);
   logic in_poll;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  in_poll <= 1'b0;
      else if (done_o)             in_poll <= 1'b0;
      else if (start_i && !in_poll) in_poll <= 1'b1;
   end

   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && !rd_valid_i |=> rd_req_o);

   p_addr_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && $past(rd_req_o) |-> $stable(rd_addr_o));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));

   p_no_req_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> in_poll && !done_o);

   p_done_in_poll_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> in_poll);
endmodule

bind tgl_poll_ctrl tgl_poll_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .done_o     (done_o),
   .result_o   (result_o),
   .rd_req_o   (rd_req_o),
   .rd_addr_o  (rd_addr_o),
   .rd_valid_i (rd_valid_i)
);

// File: tb/sim_tgl_poll_ctrl.sv
`timescale 1ns/1ps
module sim_tgl_poll_ctrl;
   localparam int AW = 16;
   localparam int DW = 8;
   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          suspend_i = 1'b0;
   logic          done_o;
   logic [1:0]    result_o;
   logic          rd_req_o;
   logic [AW-1:0] rd_addr_o;
   logic          rd_valid_i;
   logic [DW-1:0] rd_data_i;

   always #5 clk = ~clk;

   tgl_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .REPEAT_EN(1'b1), .MAX_POLLS(NP)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
      .suspend_i(suspend_i), .done_o(done_o), .result_o(result_o),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
      .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i));

   int n_chk = 0;
   int n_bad = 0;

   // flash model: bit 6 flips m_act more times (255 = forever), bit 2 flips if m_sel
   int            m_act = 0;
   logic          m_sel = 1'b0;
   logic          m_t6 = 1'b0;
   logic          m_t2 = 1'b0;
   int            m_reads = 0;
   logic [AW-1:0] m_addr = '0;
   logic          m_bad = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         rd_valid_i <= 1'b0;
         rd_data_i  <= '0;
      end else if (rd_req_o && !rd_valid_i) begin
         rd_valid_i <= 1'b1;
         rd_data_i  <= (8'hA1 & ~8'h44) | {1'b0, m_t6, 3'b000, m_t2, 2'b00};
         m_reads = m_reads + 1;
         if (rd_addr_o != m_addr) m_bad = 1'b1;
         if (m_act != 0) begin
            m_t6 = ~m_t6;
            if (m_act != 255) m_act = m_act - 1;
         end
         if (m_sel) m_t2 = ~m_t2;
      end else begin
         rd_valid_i <= 1'b0;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic launch(input logic [AW-1:0] a, input int act, input logic sel, input logic sp);
      @(negedge clk);
      m_act = act; m_sel = sel; m_reads = 0; m_addr = a; m_bad = 1'b0;
      addr_i = a; suspend_i = sp; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int k = 0; k < 400; k++) begin
         if (done_o) begin seen = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   typedef struct packed {
      logic [7:0] act;
      logic       sel;
      logic       susp;
      logic [1:0] res;
      logic [4:0] nrd;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{8'd0,   1'b0, 1'b0, 2'd0, 5'd2},   // R6 complete
      '{8'd0,   1'b1, 1'b1, 2'd2, 5'd2},   // R5
      '{8'd0,   1'b0, 1'b1, 2'd3, 5'd2},   // R6 unselected
      '{8'd0,   1'b1, 1'b0, 2'd2, 5'd2},   // R5 without flag
      '{8'd255, 1'b0, 1'b0, 2'd1, 5'd8},   // R4, R7 limit
      '{8'd255, 1'b1, 1'b0, 2'd1, 5'd8},   // R4 dominates bit 2
      '{8'd3,   1'b0, 1'b0, 2'd0, 5'd6},   // R7 settles on third pair
      '{8'd1,   1'b1, 1'b1, 2'd2, 5'd4},   // R7 settles on second pair
      '{8'd255, 1'b0, 1'b1, 2'd1, 5'd8}    // R4 flag ignored
   };

   function automatic string res_tag(input logic [1:0] r);
      case (r)
         2'd1:    return "R4 result";
         2'd2:    return "R5 result";
         default: return "R6 result";
      endcase
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected finish");
      summary();
   end

   initial begin
      bit seen;
      logic [1:0] held;
      int rd_snap;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 done_o", done_o, 0);
      chk("R1 rd_req_o", rd_req_o, 0);
      chk("R1 result_o", result_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 rd_req_o after release", rd_req_o, 0);

      for (int v = 0; v < NV; v++) begin
         launch(AW'(16'h1234 * (v + 1)), int'(VEC[v].act), VEC[v].sel, VEC[v].susp);
         wait_done(seen);
         chk("R8 done seen", seen, 1);
         chk(res_tag(VEC[v].res), result_o, VEC[v].res);
         chk("R3/R7 read count", m_reads, VEC[v].nrd);
         chk("R2 read address", m_bad, 0);
      end

      // R8: done is one cycle, result held afterwards
      launch(16'h0F0F, 0, 1'b1, 1'b0);
      wait_done(seen);
      held = result_o;
      chk("R5 result", held, 2);
      @(negedge clk);
      chk("R8 done one cycle", done_o, 0);
      rd_snap = m_reads;
      repeat (6) @(negedge clk);
      chk("R8 result held", result_o, held);
      chk("R10 no req idle", rd_req_o, 0);
      chk("R10 no reads idle", m_reads, rd_snap);

      // R9: second start during a poll is ignored
      launch(16'h00AA, 255, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      addr_i = 16'h5555; suspend_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done(seen);
      chk("R9 result", result_o, 1);
      chk("R9 read count", m_reads, 2 * NP);
      chk("R9 address kept", m_bad, 0);
      @(negedge clk);
      chk("R9 no restart", rd_req_o, 0);

      // R6: flag sampled only at start
      @(negedge clk);
      m_act = 0; m_sel = 1'b0; m_reads = 0; m_addr = 16'h0101; m_bad = 1'b0;
      addr_i = 16'h0101; suspend_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; suspend_i = 1'b0;
      wait_done(seen);
      chk("R6 flag sampled at start", result_o, 3);
      chk("R3 read count", m_reads, 2);

      summary();
   end
endmodule